// File: doc/BRIEF.md
# Bit-Slice Ripple-Carry ALU

This block is a combinational arithmetic and logic unit of configurable width, built from a row of identical one-bit slices. Each slice receives one bit of each operand, the carry from the slice below it, a shared operand-invert control and a shared two-bit function select. It returns one result bit and a carry to the slice above. The carry into the lowest slice is an input of the block, and the carry out of the highest slice is an output.

The invert control and the bit-0 carry combine with the function select to give the operations. With the invert control clear, the block performs AND, OR, add and add-plus-one. With the invert control set, the second operand is complemented before it reaches the logic and the adder. Setting the invert control and the bit-0 carry together gives two's-complement subtraction. A parameter chooses one of two internal forms for the full adder: a pair of half adders with their carries joined by an OR gate, or flat sum-of-products equations.

Top module: `rca_alu`

## Requirements
- R1: With select code 0, each result bit is the AND of the bit of `opa` and the effective bit of `opb`.
- R2: With select code 1, each result bit is the OR of the bit of `opa` and the effective bit of `opb`.
- R3: With select code 2, `{carry_out, result}` equals `opa + effective opb + carry_in`, taken over WIDTH+1 bits. Under every select code, `carry_out` is the carry of that same addition.
- R4: With select code 3, `result` is all zeros.
- R5: The effective `opb` is `opb` when `invert_b` is 0 and its bitwise complement when `invert_b` is 1. This applies to the logic functions and to the adder alike.
- R6: With `invert_b`=1, `carry_in`=1 and select code 2, `result` equals `opa - opb` modulo 2^WIDTH, and `carry_out` is 1 exactly when `opa >= opb` taken as unsigned numbers.
- R7: The carry ripples through every slice. All ones plus 1 (invert 0, carry 1, operand b zero) gives a zero result with `carry_out`=1. Zero minus one gives all ones with `carry_out`=0.
- R8: Both full-adder forms (ADDER_STYLE 0 = half-adder pair, 1 = sum of products) give identical outputs for every input.
- R9: With `invert_b`=0, `carry_in`=1 and select code 2, `result` equals `opa + opb + 1` modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, optionally complemented |
| invert_b | input | 1 | Complement `opb` before the logic and the adder |
| carry_in | input | 1 | Carry into the lowest slice |
| func_sel | input | 2 | 0 AND, 1 OR, 2 sum, 3 zero |
| result | output | WIDTH | Selected function output |
| carry_out | output | 1 | Carry from the highest slice |

## Verification
The bench builds two 4-bit copies of the block, one for each adder form. On these it sweeps every operand pair under every combination of invert, carry and select code. This covers every carry pattern the chain can produce and shows that the two forms agree. A 32-bit copy receives the longest-ripple corner cases, the subtraction borrow boundaries and random operands, which confirms that nothing in the chaining depends on a small width.

// File: rtl/rca_pkg.sv
package rca_pkg;

   typedef enum logic [1:0] {
      FN_AND  = 2'd0,
      FN_OR   = 2'd1,
      FN_SUM  = 2'd2,
      FN_ZERO = 2'd3
   } rca_fn_e;

   localparam int unsigned ADD_HALF_PAIR = 0;
   localparam int unsigned ADD_FLAT_SOP  = 1;

endpackage

// File: rtl/rca_half_adder.sv
module rca_half_adder (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   assign s = x ^ y;
   assign c = x & y;
endmodule

// File: rtl/rca_full_adder.sv
module rca_full_adder #(
   parameter int unsigned STYLE = rca_pkg::ADD_HALF_PAIR
) (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   generate
      if (STYLE == rca_pkg::ADD_HALF_PAIR) begin : g_half_pair
         logic s_lo, c_lo, c_hi;
         rca_half_adder u_ha_lo (.x(x),    .y(y),  .s(s_lo), .c(c_lo));
         rca_half_adder u_ha_hi (.x(s_lo), .y(ci), .s(s),    .c(c_hi));
         assign co = c_lo | c_hi;
      end else if (STYLE == rca_pkg::ADD_FLAT_SOP) begin : g_flat_sop
         assign s  = (x & ~y & ~ci) | (~x & y & ~ci) | (~x & ~y & ci) | (x & y & ci);
         assign co = (x & y) | ((x | y) & ci);
      end else begin : g_bad_style
         $error("rca_full_adder: STYLE must be 0 or 1");
         assign s  = 1'b0;
         assign co = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rca_slice.sv
module rca_slice #(
   parameter int unsigned ADDER_STYLE = rca_pkg::ADD_HALF_PAIR
) (
   input  logic       a_i,
   input  logic       b_i,
   input  logic       inv_i,
   input  logic       c_i,
   input  logic [1:0] fn_i,
   output logic       r_o,
   output logic       c_o
);
   import rca_pkg::*;

   logic    b_eff;
   logic    sum_bit;
   rca_fn_e fn;

   assign fn    = rca_fn_e'(fn_i);
   assign b_eff = inv_i ? ~b_i : b_i;

   rca_full_adder #(.STYLE(ADDER_STYLE)) u_fa (
      .x (a_i),
      .y (b_eff),
      .ci(c_i),
      .s (sum_bit),
      .co(c_o)
   );

   always_comb begin
      unique case (fn)
         FN_AND:  r_o = a_i & b_eff;
         FN_OR:   r_o = a_i | b_eff;
         FN_SUM:  r_o = sum_bit;
         default: r_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/rca_alu.sv
module rca_alu #(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned ADDER_STYLE = rca_pkg::ADD_HALF_PAIR
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             invert_b,
   input  logic             carry_in,
   input  logic [1:0]       func_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   localparam int unsigned CHAIN_LEN = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rca_alu: WIDTH must be at least 1");
      end
      if (ADDER_STYLE > 1) begin : g_bad_style
         $error("rca_alu: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic [CHAIN_LEN-1:0] chain;

   assign chain[0] = carry_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         rca_slice #(.ADDER_STYLE(ADDER_STYLE)) u_slice (
            .a_i  (opa[i]),
            .b_i  (opb[i]),
            .inv_i(invert_b),
            .c_i  (chain[i]),
            .fn_i (func_sel),
            .r_o  (result[i]),
            .c_o  (chain[i+1])
         );
      end
   endgenerate

   assign carry_out = chain[CHAIN_LEN-1];
endmodule

// File: rtl/rca_alu_chk.sv
module rca_alu_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             invert_b,
   input logic             carry_in,
   input logic [1:0]       func_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);
   logic [WIDTH-1:0] m_b;
   logic [WIDTH:0]   m_sum;
   logic [WIDTH-1:0] m_diff;

   always_comb begin
      m_b    = invert_b ? ~opb : opb;
      m_sum  = {1'b0, opa} + {1'b0, m_b} + {{WIDTH{1'b0}}, carry_in};
      m_diff = opa - opb;
   end

   always_comb begin
      if (func_sel == 2'd0)
         p_and_r1: assert (result == (opa & m_b)) else $error("R1 AND mismatch");
      if (func_sel == 2'd1)
         p_or_r2: assert (result == (opa | m_b)) else $error("R2 OR mismatch");
      if (func_sel == 2'd2)
         p_sum_r3: assert ({carry_out, result} == m_sum) else $error("R3 sum mismatch");
      p_carry_r3: assert (carry_out == m_sum[WIDTH]) else $error("R3 carry mismatch");
      if (func_sel == 2'd3)
         p_zero_r4: assert (result == '0) else $error("R4 zero mismatch");
      if (invert_b && carry_in && func_sel == 2'd2)
         p_sub_r6: assert (result == m_diff && carry_out == (opa >= opb))
            else $error("R6 subtract mismatch");
   end
endmodule

bind rca_alu rca_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opa      (opa),
   .opb      (opb),
   .invert_b (invert_b),
   .carry_in (carry_in),
   .func_sel (func_sel),
   .result   (result),
   .carry_out(carry_out)
);

// File: tb/rca_alu_tb.sv
module rca_alu_tb;
   localparam int SW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   logic [SW-1:0] s_a, s_b, s_r, s_r2;
   logic          s_inv, s_ci, s_co, s_co2;
   logic [1:0]    s_fn;

   logic [WW-1:0] w_a, w_b, w_r;
   logic          w_inv, w_ci, w_co;
   logic [1:0]    w_fn;

   rca_alu #(.WIDTH(SW), .ADDER_STYLE(0)) u_dut (
      .opa(s_a), .opb(s_b), .invert_b(s_inv), .carry_in(s_ci),
      .func_sel(s_fn), .result(s_r), .carry_out(s_co));

   rca_alu #(.WIDTH(SW), .ADDER_STYLE(1)) u_dut_sop (
      .opa(s_a), .opb(s_b), .invert_b(s_inv), .carry_in(s_ci),
      .func_sel(s_fn), .result(s_r2), .carry_out(s_co2));

   rca_alu #(.WIDTH(WW), .ADDER_STYLE(0)) u_dut_wide (
      .opa(w_a), .opb(w_b), .invert_b(w_inv), .carry_in(w_ci),
      .func_sel(w_fn), .result(w_r), .carry_out(w_co));

   task automatic check(input string req, input logic [WW:0] act, input logic [WW:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag_for(input logic inv, input logic ci, input logic [1:0] fn);
      string t;
      case (fn)
         2'd0: t = "R1";
         2'd1: t = "R2";
         2'd2: t = (inv && ci) ? "R6" : (!inv && ci) ? "R9" : "R3";
         default: t = "R4";
      endcase
      if (inv) t = {t, "/R5"};
      return t;
   endfunction

   function automatic logic [WW:0] wide_ref(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                            input logic inv, input logic ci, input logic [1:0] fn);
      logic [WW-1:0] be;
      logic [WW:0]   s;
      be = inv ? ~b : b;
      s  = {1'b0, a} + {1'b0, be} + {{WW{1'b0}}, ci};
      case (fn)
         2'd0: return {s[WW], a & be};
         2'd1: return {s[WW], a | be};
         2'd2: return s;
         default: return {s[WW], {WW{1'b0}}};
      endcase
   endfunction

   task automatic wide_vec(input string req, input logic [WW-1:0] a, input logic [WW-1:0] b,
                           input logic inv, input logic ci, input logic [1:0] fn);
      @(posedge clk);
      w_a = a; w_b = b; w_inv = inv; w_ci = ci; w_fn = fn;
      @(negedge clk);
      check(req, {w_co, w_r}, wide_ref(a, b, inv, ci, fn));
   endtask

   initial begin
      s_a = '0; s_b = '0; s_inv = 0; s_ci = 0; s_fn = 2'd2;
      w_a = '0; w_b = '0; w_inv = 0; w_ci = 0; w_fn = 2'd2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // zero operands under reset: sum of zeros is zero (R3)
      check("R3 zero-input", {{(WW-SW){1'b0}}, s_co, s_r}, '0);
      check("R3 zero-input wide", {w_co, w_r}, '0);
      rst_n = 1'b1;

      // exhaustive sweep on the 4-bit copies
      for (int inv = 0; inv < 2; inv++)
         for (int ci = 0; ci < 2; ci++)
            for (int fn = 0; fn < 4; fn++)
               for (int a = 0; a < 16; a++)
                  for (int b = 0; b < 16; b++) begin
                     int be, sm, er;
                     @(posedge clk);
                     s_a = SW'(a); s_b = SW'(b); s_inv = inv[0]; s_ci = ci[0]; s_fn = fn[1:0];
                     be = inv ? ((~b) & 15) : b;
                     sm = a + be + ci;
                     case (fn)
                        0: er = a & be;
                        1: er = a | be;
                        2: er = sm & 15;
                        default: er = 0;
                     endcase
                     @(negedge clk);
                     check(tag_for(inv[0], ci[0], fn[1:0]), {{(WW-SW){1'b0}}, s_co, s_r},
                           (WW+1)'(((sm >> 4) & 1) * 16 + er));
                     check("R8 flat form", {{(WW-SW){1'b0}}, s_co2, s_r2},
                           (WW+1)'(((sm >> 4) & 1) * 16 + er));
                  end

      // wide corners
      wide_vec("R7 all-ones plus one", '1, '0, 1'b0, 1'b1, 2'd2);
      check("R7 all-ones plus one result", {w_co, w_r}, {1'b1, {WW{1'b0}}});
      wide_vec("R7 zero minus one", '0, 32'd1, 1'b1, 1'b1, 2'd2);
      check("R7 zero minus one result", {w_co, w_r}, {1'b0, {WW{1'b1}}});
      wide_vec("R6 equal operands", 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, 2'd2);
      wide_vec("R6 borrow by one", 32'h8000_0000, 32'h8000_0001, 1'b1, 1'b1, 2'd2);
      wide_vec("R9 add plus one", 32'hFFFF_FFFE, 32'h0000_0000, 1'b0, 1'b1, 2'd2);
      wide_vec("R4 zero code", '1, '1, 1'b0, 1'b1, 2'd3);
      wide_vec("R1 AND inverted", 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 1'b0, 2'd0);
      wide_vec("R2 OR", 32'hA5A5_0000, 32'h0000_5A5A, 1'b0, 1'b0, 2'd1);

      for (int k = 0; k < 1200; k++) begin
         logic [WW-1:0] ra, rb;
         logic [3:0]    ctl;
         ra  = $urandom;
         rb  = $urandom;
         ctl = 4'($urandom);
         wide_vec(tag_for(ctl[3], ctl[2], ctl[1:0]), ra, rb, ctl[3], ctl[2], ctl[1:0]);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule